// File: doc/BRIEF.md
# Receive Cell Byte Bridge with Start-of-Cell Tagging

This block sits between the receive byte port of a line-side PHY and the cell reader of an ATM layer. It pulls bytes from the PHY with a read strobe and writes each byte into a single-clock FIFO. The start-of-cell marker is kept as a ninth bit of every FIFO word. The reader sees an active-low empty flag and drains the FIFO with an active-low read enable. Data and marker come out of a registered output stage.

One clock runs the PHY strobe, the FIFO write and the FIFO read, so the reader can never get ahead of the writer. When the FIFO fills, the block drops the strobe and stops writing, which can leave a cell half-moved. It keeps clocking while stalled. As soon as a word is read out, the full flag clears and the rest of the cell follows in order.

Top module: `rx_cell_bridge`

## Requirements
- R1: While `rst` is high at a rising edge, both pointers clear. After that edge `empty_n` is 0, `full_n` is 1, `phy_rd` is 1, and `rd_data`/`rd_soc` are 0.
- R2: Each stored word holds `phy_soc` as its ninth bit beside the 8-bit byte. When the word is read, `rd_soc` returns that bit together with the byte on `rd_data`.
- R3: A byte is written at a rising edge only when `phy_valid` is 1 and the FIFO holds fewer than DEPTH words. `full_n` is 0 exactly when DEPTH words are held.
- R4: `phy_rd` is 0 exactly while `full_n` is 0, so no byte is taken from the PHY during a full stall.
- R5: A cell cut off by a full stall resumes after the stall with its remaining bytes in the original order. No byte is lost and none is repeated.
- R6: `empty_n` goes to 1 after the first rising edge that writes a byte into an empty FIFO, with only that one byte held.
- R7: If `rd_en_n` is 0 at a rising edge and the FIFO is not empty, that edge loads the oldest word onto `rd_data`/`rd_soc` and removes it.
- R8: If `rd_en_n` is 0 at a rising edge while the FIFO is empty, the read is ignored. `rd_data`, `rd_soc` and `empty_n` keep their values.
- R9: A read at a rising edge while full frees one word. After that edge `full_n` is 1 and `phy_rd` is 1, even though no write took place in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for PHY strobe, FIFO write and FIFO read |
| rst | input | 1 | Synchronous active-high reset |
| phy_data | input | 8 | Byte presented by the PHY |
| phy_soc | input | 1 | Start-of-cell marker for the presented byte |
| phy_valid | input | 1 | PHY has a byte on `phy_data` this cycle |
| phy_rd | output | 1 | Read strobe to the PHY, high while the FIFO can accept a byte |
| rd_en_n | input | 1 | Active-low read enable from the ATM-layer reader |
| empty_n | output | 1 | Active-low empty flag, high when at least one word is held |
| full_n | output | 1 | Active-low full flag, low when DEPTH words are held |
| rd_data | output | 8 | Byte of the last word read |
| rd_soc | output | 1 | Start-of-cell bit of the last word read |

## Verification
A pointer that slips or wraps wrongly appears at the ports as a byte out of sequence on `rd_data`. It can also show as a marker on `rd_soc` that lands off the cell boundary. Either shows on the first read after the fault. A wrong full or empty decision shows up in the next cycle as a mismatch between `phy_rd`, `full_n` or `empty_n` and the count of words written minus words read. The bench feeds a numbered byte stream with a marker every 53 bytes, so each read word identifies exactly which byte should have arrived. A lost, doubled or reordered byte around a stall therefore fails at the read that returns it.

// File: rtl/rx_cell_bridge.sv
module rx_cell_bridge #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] phy_data,
  input  logic          phy_soc,
  input  logic          phy_valid,
  output logic          phy_rd,
  input  logic          rd_en_n,
  output logic          empty_n,
  output logic          full_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_soc
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0] wp, rp;
  logic [DW:0] mem [DEPTH];
  logic        full, empty, wr, rd;

  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty = (wp == rp);
  assign wr    = phy_valid & ~full;
  assign rd    = ~rd_en_n & ~empty;

  assign phy_rd  = ~full;
  assign full_n  = ~full;
  assign empty_n = ~empty;

  always_ff @(posedge clk)
    if (wr) mem[wp[AW-1:0]] <= {phy_soc, phy_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      rd_data <= '0;
      rd_soc  <= 1'b0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) begin
        {rd_soc, rd_data} <= mem[rp[AW-1:0]];
        rp <= rp + 1'b1;
      end
    end
  end
endmodule

module rx_cell_bridge_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          phy_valid,
  input logic          phy_rd,
  input logic          rd_en_n,
  input logic          empty_n,
  input logic          full_n,
  input logic [DW-1:0] rd_data,
  input logic          rd_soc,
  input logic [AW:0]   wp,
  input logic [AW:0]   rp
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !full_n |=> $stable(wp)); // R3
  AST_STROBE_RESUMES: assert property (@(posedge clk) disable iff (rst)
    $rose(full_n) |-> phy_rd); // R9
  AST_ONE_BYTE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && phy_valid && phy_rd) |=> empty_n); // R6
  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_n && empty_n) |=> (rp == $past(rp) + 1'b1)); // R7
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_n && !empty_n) |=> ($stable(rd_data) && $stable(rd_soc) && $stable(rp))); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~empty_n, ~full_n})); // R3
endmodule

bind rx_cell_bridge rx_cell_bridge_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .phy_valid(phy_valid), .phy_rd(phy_rd),
  .rd_en_n(rd_en_n), .empty_n(empty_n), .full_n(full_n),
  .rd_data(rd_data), .rd_soc(rd_soc), .wp(wp), .rp(rp));

// File: tb/rx_cell_bridge_tb.sv
`timescale 1ns/1ps
module rx_cell_bridge_tb_top;
  localparam int DEPTH = 64;
  localparam int CELL  = 53;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] phy_data;
  logic phy_soc, phy_valid, rd_en_n;
  logic phy_rd, empty_n, full_n, rd_soc;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int cnt = 0, wr_idx = 0, rd_idx = 0;
  logic [7:0] exp_data = 8'h00;
  logic exp_soc = 1'b0;
  bit empty_read = 0, stalled = 0;

  always #4 clk = ~clk;

  rx_cell_bridge #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .phy_data(phy_data), .phy_soc(phy_soc),
    .phy_valid(phy_valid), .phy_rd(phy_rd), .rd_en_n(rd_en_n),
    .empty_n(empty_n), .full_n(full_n), .rd_data(rd_data), .rd_soc(rd_soc));

  function automatic logic [7:0] byte_of(int k);
    return 8'(k * 37 + (k >> 3));
  endfunction
  function automatic logic soc_of(int k);
    return (k % CELL) == 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    string t;
    t = empty_read ? "R8" : (stalled ? "R5" : "R7");
    check(rd_data == exp_data, t, rd_data, exp_data);
    check(rd_soc == exp_soc, "R2", rd_soc, exp_soc);
    check(empty_n == (cnt > 0), "R6", empty_n, cnt > 0);
    check(full_n == (cnt < DEPTH), "R3", full_n, cnt < DEPTH);
    check(phy_rd == (cnt < DEPTH), "R4", phy_rd, cnt < DEPTH);
  endtask

  // one clock: check, drive, predict next edge
  task automatic step(int vld_pct, int rd_pct);
    bit w, r;
    @(negedge clk);
    check_outputs();
    phy_valid = ($urandom % 100) < vld_pct;
    rd_en_n   = !(($urandom % 100) < rd_pct);
    phy_data  = byte_of(wr_idx);
    phy_soc   = soc_of(wr_idx);
    w = phy_valid && cnt < DEPTH;
    r = !rd_en_n && cnt > 0;
    if (cnt == DEPTH) stalled = 1;
    empty_read = !rd_en_n && cnt == 0;
    if (r) begin
      exp_data = byte_of(rd_idx);
      exp_soc  = soc_of(rd_idx);
      rd_idx++;
    end
    if (w) wr_idx++;
    cnt = cnt + int'(w) - int'(r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; phy_valid = 1'b0; rd_en_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cnt = 0; rd_idx = wr_idx; exp_data = 8'h00; exp_soc = 1'b0;
    empty_read = 0; stalled = 0;
    check(empty_n == 1'b0, "R1", empty_n, 0);
    check(full_n == 1'b1, "R1", full_n, 1);
    check(phy_rd == 1'b1, "R1", phy_rd, 1);
    check(rd_data == 8'h00 && rd_soc == 1'b0, "R1", {rd_soc, rd_data}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    phy_valid = 1'b0; rd_en_n = 1'b1; phy_data = '0; phy_soc = 1'b0;
    do_reset();
    // R8: reads on an empty FIFO
    for (int i = 0; i < 4; i++) step(0, 100);
    // R6: single byte written, then idle
    step(100, 0);
    step(0, 0);
    // R3/R4: fill to full and stall mid-cell
    for (int i = 0; i < DEPTH + 10; i++) step(100, 0);
    // R9: one read while full with valid input
    step(100, 100);
    step(0, 0);
    // R5: drain after the stall
    for (int i = 0; i < DEPTH + 5; i++) step(0, 100);
    // random mix
    for (int i = 0; i < 3000; i++) step(70, 50);
    for (int i = 0; i < 3000; i++) step(95, 20);
    for (int i = 0; i < 3000; i++) step(30, 90);
    // R1: reset in the middle of traffic
    for (int i = 0; i < 20; i++) step(100, 0);
    do_reset();
    for (int i = 0; i < 2000; i++) step(60, 60);
    for (int i = 0; i < DEPTH + 5; i++) step(0, 100);
    step(0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule